// File: doc/BRIEF.md
# Serial EEPROM Image Loader with XOR Integrity Check

This block fetches a small configuration image from a three-wire-plus-select serial EEPROM (64 words of 16 bits) without any processor help. It starts on its own when reset is released, and again on every `start` pulse. For each 16-bit word it opens a separate chip-select window. In that window it sends a start bit, the read opcode and the word address. It then clocks the data word back in and places the two bytes in a 32-byte register file. A clock divider stretches every line state so that slow serial parts can be used.

Once the last word is in, the block XORs a configured range of image bytes. It compares the result with the checksum byte stored in the image and raises an error flag on a mismatch. A 48-bit station address is taken from six consecutive bytes at a fixed position and is always visible on an output. A done flag marks the end of the load and the point at which the error flag and the station address are final.

Top module: `eeprom_image_loader`

## Requirements
- R1: After reset is released, and after every `start` pulse, the block reads words 0 to NUM_WORDS-1 in ascending order. Each word has its own `eeCs` high window, and `eeCs` goes low between two words. `eeSk` is never high while `eeCs` is low.
- R2: Inside each window the block sends 3+ADDR_BITS bits on `eeDi`, most significant first: 1, 1, 0, then the word index as an ADDR_BITS-bit address. `eeDi` is set while `eeSk` is low and does not change while `eeSk` is high.
- R3: After the address, one step passes with `eeCs` high and `eeSk` low. Then 16 data bits are read: for each bit `eeSk` goes high, then low, and `eeDo` is sampled at the end of the low step. The first 8 bits, most significant first, go to image byte 2w and the last 8 bits go to byte 2w+1, where w is the word index.
- R4: Every line state is held for exactly CLK_DIV clock cycles, so each high pulse on `eeSk` lasts CLK_DIV cycles.
- R5: `ckErr` is 1 when the XOR of image bytes KEY_FIRST up to CKSUM_POS-1 differs from image byte CKSUM_POS, and 0 when they are equal. It is valid from the cycle `done` rises.
- R6: `stationAddr` holds image bytes MAC_POS to MAC_POS+5, with byte MAC_POS in bits 47:40 and byte MAC_POS+5 in bits 7:0.
- R7: `done` rises once the last word has been stored and the checksum compared. It then stays high with all serial lines low until `start`. A `start` pulse, even in the middle of a load, drops `done` on the next cycle and begins a new load at word 0.
- R8: While reset is asserted, `eeCs`, `eeSk`, `eeDi`, `done` and `ckErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts (or restarts) a load |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Serial data into the EEPROM |
| eeDo | input | 1 | Serial data from the EEPROM |
| done | output | 1 | Load and checksum compare finished |
| ckErr | output | 1 | Checksum mismatch |
| stationAddr | output | 48 | Six image bytes starting at MAC_POS |

## Verification
The bench builds the loader with CLK_DIV=3, NUM_WORDS=16, ADDR_BITS=6, KEY_FIRST=4, CKSUM_POS=17 and MAC_POS=10. A divider above one makes the hold time of each line state measurable. The odd checksum position puts the checksum byte in the low half of a word, and the station address spans three words, so the byte order within a word is checked at both halves. A behavioural serial EEPROM in the bench answers with several seeded images, each with a correct or a deliberately spoiled checksum. Because every byte of the image can be computed, every load, including one restarted in the middle, can be checked in full.

// File: rtl/eeld_pkg.sv
package eeld_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic shiftIn;    // sample eeDo into the word shifter
    logic storeWord;  // commit shifted word to the byte file
    logic finish;     // latch the checksum compare result
    logic clear;      // new load begins: clear the error flag
  } eeld_strobe_t;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_FINISH = 2'd1,
    ST_DONE   = 2'd2
  } eeld_state_e;

endpackage

// File: rtl/eeld_ctrl.sv
module eeld_ctrl
  import eeld_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int NUM_WORDS = 16,
  parameter int ADDR_BITS = 6,
  parameter int WORD_W    = 16,
  localparam int IDXW     = $clog2(NUM_WORDS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  output logic            eeCs,
  output logic            eeSk,
  output logic            eeDi,
  output logic            done,
  output logic [IDXW-1:0] wordIdx,
  output eeld_strobe_t    strb
);

  localparam int CMD_BITS = 3 + ADDR_BITS;
  localparam int PH_CMD0  = 2;
  localparam int PH_GAP   = PH_CMD0 + 2 * CMD_BITS;
  localparam int PH_DAT0  = PH_GAP + 1;
  localparam int PH_LAST  = PH_DAT0 + 2 * WORD_W - 1;
  localparam int PHW      = $clog2(PH_LAST + 1);
  localparam int DIVW     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  localparam logic [PHW-1:0]  P_CMD0 = PHW'(PH_CMD0);
  localparam logic [PHW-1:0]  P_GAP  = PHW'(PH_GAP);
  localparam logic [PHW-1:0]  P_DAT0 = PHW'(PH_DAT0);
  localparam logic [PHW-1:0]  P_LAST = PHW'(PH_LAST);
  localparam logic [DIVW-1:0] D_LAST = DIVW'(CLK_DIV - 1);
  localparam logic [IDXW-1:0] W_LAST = IDXW'(NUM_WORDS - 1);

  eeld_state_e     state;
  logic [PHW-1:0]  phase;
  logic [DIVW-1:0] divCnt;
  logic            tick;
  logic            running;
  logic [PHW-1:0]  cmdOff;
  logic [PHW-1:0]  datOff;
  logic [CMD_BITS-1:0] cmdVec;
  logic [CMD_BITS-1:0] cmdShift;
  logic            inCmd;
  logic            inDat;

  assign running  = (state == ST_RUN);
  assign tick     = (divCnt == D_LAST);
  assign cmdOff   = phase - P_CMD0;
  assign datOff   = phase - P_DAT0;
  assign cmdVec   = {3'b110, ADDR_BITS'(wordIdx)};
  assign cmdShift = cmdVec << (cmdOff >> 1);
  assign inCmd    = running && (phase >= P_CMD0) && (phase < P_GAP);
  assign inDat    = running && (phase >= P_DAT0);

  // Serial line decode from the phase counter.
  always_comb begin
    eeCs = running && (phase != '0);
    eeSk = 1'b0;
    eeDi = 1'b0;
    if (inCmd) begin
      eeDi = cmdShift[CMD_BITS-1];
      eeSk = cmdOff[0];
    end else if (inDat) begin
      eeSk = ~datOff[0];
    end
  end

  always_comb begin
    strb.clear     = start;
    strb.shiftIn   = !start && inDat && tick && datOff[0];
    strb.storeWord = !start && running && tick && (phase == P_LAST);
    strb.finish    = !start && (state == ST_FINISH);
  end

  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      phase   <= '0;
      divCnt  <= '0;
      wordIdx <= '0;
    end else if (start) begin
      state   <= ST_RUN;
      phase   <= '0;
      divCnt  <= '0;
      wordIdx <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          divCnt <= tick ? '0 : divCnt + 1'b1;
          if (tick) begin
            if (phase == P_LAST) begin
              phase <= '0;
              if (wordIdx == W_LAST) state <= ST_FINISH;
              else                   wordIdx <= wordIdx + 1'b1;
            end else begin
              phase <= phase + 1'b1;
            end
          end
        end
        ST_FINISH: state <= ST_DONE;
        default:   state <= ST_DONE;
      endcase
    end
  end

  // R1
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    eeSk |-> eeCs);

  // R2
  di_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eeSk && $past(eeSk)) |-> $stable(eeDi));

  // R7
  done_lines_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!eeCs && !eeSk && !eeDi));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R7
  start_drops_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);

endmodule

// File: rtl/eeld_datapath.sv
module eeld_datapath
  import eeld_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 16,
  parameter int KEY_FIRST = 4,
  parameter int CKSUM_POS = 17,
  parameter int MAC_POS   = 10,
  localparam int IDXW      = $clog2(NUM_WORDS),
  localparam int NUM_BYTES = NUM_WORDS * 2,
  localparam int BIDXW     = IDXW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  eeld_strobe_t    strb,
  input  logic [IDXW-1:0] wordIdx,
  input  logic            eeDo,
  output logic            ckErr,
  output logic [47:0]     stationAddr
);

  logic [WORD_W-1:0] shReg;
  logic [WORD_W-1:0] nextWord;
  logic [7:0]        img [NUM_BYTES];
  logic [7:0]        xorSum;
  logic [BIDXW-1:0]  evenIdx;
  logic [BIDXW-1:0]  oddIdx;

  assign nextWord = {shReg[WORD_W-2:0], eeDo};
  assign evenIdx  = {wordIdx, 1'b0};
  assign oddIdx   = {wordIdx, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strb.shiftIn) shReg <= nextWord;
  end

  // First received byte lands at the even index.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BYTES; i++) img[i] <= '0;
    end else if (strb.storeWord) begin
      img[evenIdx] <= nextWord[WORD_W-1 -: 8];
      img[oddIdx]  <= nextWord[7:0];
    end
  end

  always_comb begin
    xorSum = '0;
    for (int i = KEY_FIRST; i < CKSUM_POS; i++) xorSum ^= img[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ckErr <= 1'b0;
    else if (strb.clear)   ckErr <= 1'b0;
    else if (strb.finish)  ckErr <= (xorSum != img[CKSUM_POS]);
  end

  for (genvar g = 0; g < 6; g++) begin : g_mac
    assign stationAddr[47-8*g -: 8] = img[MAC_POS+g];
  end

  // R5
  ckerr_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ckErr) |-> $past(strb.finish || strb.clear));

  // R3
  store_after_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeWord |-> strb.shiftIn);

endmodule

// File: rtl/eeprom_image_loader.sv
module eeprom_image_loader
  import eeld_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int NUM_WORDS = 16,
  parameter int ADDR_BITS = 6,
  parameter int KEY_FIRST = 4,
  parameter int CKSUM_POS = 17,
  parameter int MAC_POS   = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        eeCs,
  output logic        eeSk,
  output logic        eeDi,
  input  logic        eeDo,
  output logic        done,
  output logic        ckErr,
  output logic [47:0] stationAddr
);

  localparam int IDXW   = $clog2(NUM_WORDS);
  localparam int WORD_W = 16;

  eeld_strobe_t    strb;
  logic [IDXW-1:0] wordIdx;

  eeld_ctrl #(
    .CLK_DIV(CLK_DIV), .NUM_WORDS(NUM_WORDS),
    .ADDR_BITS(ADDR_BITS), .WORD_W(WORD_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi),
    .done(done), .wordIdx(wordIdx), .strb(strb)
  );

  eeld_datapath #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .KEY_FIRST(KEY_FIRST),
    .CKSUM_POS(CKSUM_POS), .MAC_POS(MAC_POS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIdx(wordIdx),
    .eeDo(eeDo), .ckErr(ckErr), .stationAddr(stationAddr)
  );

endmodule

// File: tb/test_eeprom_image_loader.sv
module test_eeprom_image_loader;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int NWORDS     = 16;
  localparam int KEYF       = 4;
  localparam int CKP        = 17;
  localparam int MACP       = 10;

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic eeCs, eeSk, eeDi, done, ckErr;
  logic eeDo = 0;
  logic [47:0] stationAddr;

  int nTests = 0;
  int nFail  = 0;

  int seed = 0;
  bit bad  = 0;

  // EEPROM model state
  int bitCnt = 0;
  int outIdx = 0;
  logic [8:0] cmd = '0;
  int addrLog [NWORDS];
  int nLog = 0;
  bit cmdOk = 1;
  bit dataCntOk = 1;

  // Sk high-time monitor
  int hiCnt = 0;
  int skBad = 0;
  int nHigh = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_image_loader #(
    .CLK_DIV(DIV), .NUM_WORDS(NWORDS), .ADDR_BITS(6),
    .KEY_FIRST(KEYF), .CKSUM_POS(CKP), .MAC_POS(MACP)
  ) i_eeprom_image_loader (
    .clk(clk), .rstN(rstN), .start(start),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo),
    .done(done), .ckErr(ckErr), .stationAddr(stationAddr)
  );

  function automatic logic [7:0] rawByte(int s, int i);
    return 8'((i * 37 + s * 53 + 11) & 255);
  endfunction

  function automatic logic [7:0] imgByte(int s, bit b, int i);
    logic [7:0] x;
    if (i != CKP) return rawByte(s, i);
    x = '0;
    for (int j = KEYF; j < CKP; j++) x ^= rawByte(s, j);
    return b ? (x ^ 8'h5A) : x;
  endfunction

  function automatic logic [15:0] memWord(int s, bit b, int a);
    return {imgByte(s, b, 2 * a), imgByte(s, b, 2 * a + 1)};
  endfunction

  // Behavioural serial EEPROM: 9 command bits, then data on rising clocks.
  always @(posedge eeSk or negedge eeCs) begin
    if (!eeCs) begin
      if (bitCnt >= 9 && nLog < NWORDS) begin
        addrLog[nLog] = int'(cmd[5:0]);
        if (cmd[8:6] != 3'b110) cmdOk = 0;
        if (outIdx != 16) dataCntOk = 0;
        nLog++;
      end
      bitCnt = 0;
      outIdx = 0;
      eeDo   = 0;
    end else if (bitCnt < 9) begin
      cmd = {cmd[7:0], eeDi};
      bitCnt++;
    end else begin
      logic [15:0] w;
      w = memWord(seed, bad, int'(cmd[5:0]));
      eeDo = (outIdx < 16) ? w[15 - outIdx] : 1'b0;
      outIdx++;
    end
  end

  always @(negedge clk) begin
    if (eeSk) hiCnt++;
    else if (hiCnt != 0) begin
      if (hiCnt != DIV) skBad++;
      nHigh++;
      hiCnt = 0;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    nLog = 0; cmdOk = 1; dataCntOk = 1; skBad = 0; nHigh = 0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic checkLoad(string tag);
    bit ok;
    bit seqOk;
    logic [47:0] expMac;
    waitDone(ok);
    check(ok, "R7", {tag, " done within timeout"}, ok, 1);
    if (!ok) return;
    seqOk = (nLog == NWORDS);
    for (int i = 0; i < NWORDS; i++) if (i < nLog && addrLog[i] != i) seqOk = 0;
    // R1 word order and per-word select windows
    check(seqOk, "R1", {tag, " address sequence"}, nLog, NWORDS);
    // R2 command bits 1,1,0
    check(cmdOk, "R2", {tag, " opcode"}, cmdOk, 1);
    check(dataCntOk, "R3", {tag, " 16 data clocks"}, dataCntOk, 1);
    // R4 sk high time
    check(skBad == 0 && nHigh > 0, "R4", {tag, " sk high = DIV"}, skBad, 0);
    // R5 checksum
    check(ckErr == bad, "R5", {tag, " ckErr"}, ckErr, bad);
    for (int g = 0; g < 6; g++) expMac[47 - 8*g -: 8] = imgByte(seed, bad, MACP + g);
    // R6 / R3 byte order
    check(stationAddr == expMac, "R6", {tag, " stationAddr"}, stationAddr, expMac);
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    // R7 done drops right after start
    check(!done, "R7", "done low after start", done, 0);
    @(negedge clk); @(negedge clk);
    clearLog();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    seed = 0; bad = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!eeCs && !eeSk && !eeDi && !done && !ckErr, "R8", "reset state",
          {eeCs, eeSk, eeDi, done, ckErr}, 0);
    clearLog();
    rstN = 1;
    checkLoad("auto load");

    for (int s = 1; s <= 4; s++) begin
      seed = s * 7; bad = s[0];
      pulseStart();
      checkLoad(bad ? "bad sum" : "good sum");
    end

    // Restart mid-load with a new image
    seed = 99; bad = 1;
    pulseStart();
    repeat (700) @(negedge clk);
    seed = 42; bad = 0;
    pulseStart();
    checkLoad("restart");

    // R7 done held, lines quiet
    begin
      bit held = 1;
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        if (!done || eeCs || eeSk || eeDi) held = 0;
      end
      check(held, "R7", "done held with lines low", held, 1);
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule